// File: doc/BRIEF.md
# Multi-Slope Exposure Sequencer

This block produces the exposure control pulses for one frame of a pixel array that can use dual-slope and triple-slope integration. A start pulse opens a frame. All pixels are first held in a global reset. The main integration window follows. Inside that window, up to two short partial-reset "knee" pulses may fire. Each knee pulse is placed so that the time left until the end of the window equals the dual-slope or the triple-slope integration time. A one-cycle done pulse marks the end of integration.

Every duration comes from a setting input. One mode bit chooses the unit for all durations. In clock mode, every clock cycle counts as one unit. In line mode, only cycles carrying a one-cycle line strobe count. All settings are captured when a frame is accepted, so the register block that drives them may change them freely while a frame runs.

Top module: `exp_seq`

## Requirements
- R1: When `start` is sampled high while no frame runs, `glob_rst` goes high in the next cycle and stays high for exactly `reset_len` units. `integrating` stays low during that time.
- R2: When the global reset ends, `integrating` is high for exactly `integ_main` units. `done` is then high for exactly one cycle: the first cycle in which `integrating` is low again.
- R3: With `unit_is_clk` = 1, each clock cycle is one unit. With `unit_is_clk` = 0, a unit is counted only at a clock edge where `line_tick` is high, and cycles without a tick do not advance any duration. The strobe at the edge that accepts `start` is not counted.
- R4: With `ds_enable` = 1, `ds_rst` is high during integration from elapsed unit `integ_main - integ_ds` for `knee_len` units. The pulse is cut off when integration ends. With `ds_enable` = 0, `ds_rst` stays low.
- R5: With `ts_enable` = 1, `ts_rst` is high during integration from elapsed unit `integ_main - integ_ts` for `knee_len` units. The pulse is cut off when integration ends. With `ts_enable` = 0, `ts_rst` stays low.
- R6: An `integ_ds` larger than the main time acts as the main time. An `integ_ts` larger than the effective dual-slope time acts as that time.
- R7: A value of zero in any duration setting acts as one unit.
- R8: A `start` sampled while a frame is in its reset or integration phase has no effect on any output.
- R9: Settings, enables and the unit mode are captured at the edge that accepts `start`. Later changes to them have no effect on the running frame.
- R10: While `rst_n` is low, and right after it rises, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame start request |
| line_tick | input | 1 | One-cycle line period strobe |
| unit_is_clk | input | 1 | 1: durations in clock cycles; 0: in line periods |
| ds_enable | input | 1 | Enable dual-slope knee pulse |
| ts_enable | input | 1 | Enable triple-slope knee pulse |
| reset_len | input | CNT_W | Global reset length |
| knee_len | input | CNT_W | Knee pulse width |
| integ_main | input | CNT_W | Main integration time |
| integ_ds | input | CNT_W | Dual-slope integration time |
| integ_ts | input | CNT_W | Triple-slope integration time |
| glob_rst | output | 1 | Global pixel reset |
| ds_rst | output | 1 | Dual-slope knee reset |
| ts_rst | output | 1 | Triple-slope knee reset |
| integrating | output | 1 | Main integration window |
| done | output | 1 | One-cycle end-of-integration pulse |

## Verification
The bench builds the block with `CNT_W` = 8. With that width, a full-scale duration of 255 units can be run in clock mode within a short run. The same clamp and zero-as-one logic is covered as at the default width. The small width also allows a knee width far larger than the window, which exercises truncation at the end of integration. Line-mode frames use a strobe every two or three cycles, so that idle cycles between units are observed.

// File: rtl/exp_seq_pkg.sv
// Shared definitions for the exposure sequencer.
// Assumes: two knee channels, dual-slope at index 0 and triple-slope at index 1.
package exp_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RESET = 2'd1,
        PH_INTEG = 2'd2
    } exp_phase_e;

    localparam int NUM_KNEES = 2;
    localparam int KNEE_DS   = 0;
    localparam int KNEE_TS   = 1;
endpackage

// File: rtl/exp_cfg_clamp.sv
// Turns raw duration settings into effective ones.
// A zero becomes one. The dual-slope time is limited to the main time, and the
// triple-slope time to the dual-slope time. Outputs the knee start offsets.
// Assumes: purely combinational; the caller captures the results.
module exp_cfg_clamp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] raw_rst,
    input  logic [CNT_W-1:0] raw_knee,
    input  logic [CNT_W-1:0] raw_main,
    input  logic [CNT_W-1:0] raw_ds,
    input  logic [CNT_W-1:0] raw_ts,
    output logic [CNT_W-1:0] eff_rst,
    output logic [CNT_W-1:0] eff_knee,
    output logic [CNT_W-1:0] eff_main,
    output logic [CNT_W-1:0] ds_at,
    output logic [CNT_W-1:0] ts_at
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] ds_nz, ts_nz, eff_ds, eff_ts;

    // Replace zero settings by one unit.
    always_comb begin
        eff_rst  = (raw_rst  == '0) ? ONE : raw_rst;
        eff_knee = (raw_knee == '0) ? ONE : raw_knee;
        eff_main = (raw_main == '0) ? ONE : raw_main;
        ds_nz    = (raw_ds   == '0) ? ONE : raw_ds;
        ts_nz    = (raw_ts   == '0) ? ONE : raw_ts;
    end

    // Enforce main >= dual >= triple and derive the knee start points.
    always_comb begin
        eff_ds = (ds_nz > eff_main) ? eff_main : ds_nz;
        eff_ts = (ts_nz > eff_ds) ? eff_ds : ts_nz;
        ds_at  = eff_main - eff_ds;
        ts_at  = eff_main - eff_ts;
    end
endmodule

// File: rtl/exp_phase_ctrl.sv
// Frame phase machine with a shared unit counter.
// Idle -> global reset -> integration -> idle, with a one-cycle done pulse at the end.
// Assumes: lengths are at least one and stable from the cycle after accept.
// adv marks a unit boundary.
module exp_phase_ctrl
    import exp_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             adv,
    input  logic [CNT_W-1:0] len_rst,
    input  logic [CNT_W-1:0] len_main,
    output exp_phase_e       phase,
    output logic [CNT_W-1:0] cnt,
    output logic             accept,
    output logic             done
);
    logic [CNT_W-1:0] limit;
    logic             last_unit;

    // Accept a start only when no frame is running.
    assign accept = (phase == PH_IDLE) && start;

    // Terminal count of the current phase.
    always_comb begin
        limit     = (phase == PH_RESET) ? len_rst : len_main;
        last_unit = adv && (cnt == limit - CNT_W'(1));
    end

    // Advance phase and unit count; raise done on the final integration unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_RESET;
                        cnt   <= '0;
                    end
                end
                PH_RESET: begin
                    if (last_unit) begin
                        phase <= PH_INTEG;
                        cnt   <= '0;
                    end else if (adv) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_INTEG: begin
                    if (last_unit) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                        done  <= 1'b1;
                    end else if (adv) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/exp_knee_window.sv
// Decodes one knee reset pulse from the integration unit count.
// Assumes: at < main time, so the window opens inside integration.
// The window closes when integration ends.
module exp_knee_window #(
    parameter int CNT_W = 16
) (
    input  logic             enable,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] at,
    input  logic [CNT_W-1:0] width,
    output logic             pulse
);
    logic [CNT_W-1:0] offset;

    // The pulse is high while the count lies in [at, at + width).
    always_comb begin
        offset = cnt - at;
        pulse  = enable && active && (cnt >= at) && (offset < width);
    end
endmodule

// File: rtl/exp_seq.sv
// Multi-slope exposure sequencer top.
// Captures the settings at frame accept, runs the phase machine in clock or
// line units, and decodes the knee pulses.
// Assumes: line_tick is a one-cycle strobe in the clk domain.
module exp_seq
    import exp_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             line_tick,
    input  logic             unit_is_clk,
    input  logic             ds_enable,
    input  logic             ts_enable,
    input  logic [CNT_W-1:0] reset_len,
    input  logic [CNT_W-1:0] knee_len,
    input  logic [CNT_W-1:0] integ_main,
    input  logic [CNT_W-1:0] integ_ds,
    input  logic [CNT_W-1:0] integ_ts,
    output logic             glob_rst,
    output logic             ds_rst,
    output logic             ts_rst,
    output logic             integrating,
    output logic             done
);
    logic [CNT_W-1:0] eff_rst, eff_knee, eff_main, ds_at, ts_at;
    logic [CNT_W-1:0] rst_q, knee_q, main_q;
    logic [CNT_W-1:0] at_q  [NUM_KNEES];
    logic             en_q  [NUM_KNEES];
    logic             knee_pulse [NUM_KNEES];
    logic             mode_q;
    logic             adv;
    logic             accept;
    logic [CNT_W-1:0] cnt;
    exp_phase_e       phase;

    exp_cfg_clamp #(.CNT_W(CNT_W)) u_clamp (
        .raw_rst (reset_len),
        .raw_knee(knee_len),
        .raw_main(integ_main),
        .raw_ds  (integ_ds),
        .raw_ts  (integ_ts),
        .eff_rst (eff_rst),
        .eff_knee(eff_knee),
        .eff_main(eff_main),
        .ds_at   (ds_at),
        .ts_at   (ts_at)
    );

    // Capture the frame settings when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q           <= '0;
            knee_q          <= '0;
            main_q          <= '0;
            mode_q          <= 1'b0;
            at_q[KNEE_DS]   <= '0;
            at_q[KNEE_TS]   <= '0;
            en_q[KNEE_DS]   <= 1'b0;
            en_q[KNEE_TS]   <= 1'b0;
        end else if (accept) begin
            rst_q           <= eff_rst;
            knee_q          <= eff_knee;
            main_q          <= eff_main;
            mode_q          <= unit_is_clk;
            at_q[KNEE_DS]   <= ds_at;
            at_q[KNEE_TS]   <= ts_at;
            en_q[KNEE_DS]   <= ds_enable;
            en_q[KNEE_TS]   <= ts_enable;
        end
    end

    // A unit passes every cycle in clock mode, or on each strobe in line mode.
    assign adv = mode_q | line_tick;

    exp_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .adv     (adv),
        .len_rst (rst_q),
        .len_main(main_q),
        .phase   (phase),
        .cnt     (cnt),
        .accept  (accept),
        .done    (done)
    );

    // One window decoder per knee channel.
    for (genvar k = 0; k < NUM_KNEES; k++) begin : g_knee
        exp_knee_window #(.CNT_W(CNT_W)) u_win (
            .enable(en_q[k]),
            .active(phase == PH_INTEG),
            .cnt   (cnt),
            .at    (at_q[k]),
            .width (knee_q),
            .pulse (knee_pulse[k])
        );
    end

    // Phase and knee outputs.
    assign glob_rst    = (phase == PH_RESET);
    assign integrating = (phase == PH_INTEG);
    assign ds_rst      = knee_pulse[KNEE_DS];
    assign ts_rst      = knee_pulse[KNEE_TS];
endmodule

// File: rtl/exp_seq_chk.sv
// Temporal checks on the exposure sequencer outputs; bound into exp_seq.
// Assumes: mode_q is the captured unit mode inside the sequencer.
module exp_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic line_tick,
    input logic mode_q,
    input logic glob_rst,
    input logic ds_rst,
    input logic ts_rst,
    input logic integrating,
    input logic done
);
    // R1: reset and integration never overlap.
    p_phase_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(glob_rst && integrating));

    // R2: done follows the last integration cycle.
    p_done_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!integrating && $past(integrating)));

    // R2: done lasts a single cycle.
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: in line mode the reset holds while no strobe arrives.
    p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_rst && !mode_q && !line_tick) |=> glob_rst);

    // R4: the dual-slope knee occurs only inside integration.
    p_ds_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ds_rst |-> integrating);

    // R5: the triple-slope knee occurs only inside integration.
    p_ts_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ts_rst |-> integrating);

    // R8: a start during integration does not restart the reset.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (integrating && start) |=> !glob_rst);
endmodule

bind exp_seq exp_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .line_tick  (line_tick),
    .mode_q     (mode_q),
    .glob_rst   (glob_rst),
    .ds_rst     (ds_rst),
    .ts_rst     (ts_rst),
    .integrating(integrating),
    .done       (done)
);

// File: tb/tb_exp_seq.sv
`timescale 1ns/1ps
module tb_exp_seq;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, start, line_tick, unit_is_clk, ds_enable, ts_enable;
    logic [W-1:0] reset_len, knee_len, integ_main, integ_ds, integ_ts;
    logic glob_rst, ds_rst, ts_rst, integrating, done;

    exp_seq #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .line_tick(line_tick),
        .unit_is_clk(unit_is_clk), .ds_enable(ds_enable), .ts_enable(ts_enable),
        .reset_len(reset_len), .knee_len(knee_len), .integ_main(integ_main),
        .integ_ds(integ_ds), .integ_ts(integ_ts),
        .glob_rst(glob_rst), .ds_rst(ds_rst), .ts_rst(ts_rst),
        .integrating(integrating), .done(done)
    );

    int checks = 0;
    int errors = 0;
    string frame_tag = "R10";

    // Scoreboard entries: {glob, ds, ts, integ, done}.
    logic [4:0] sb_q[$];

    // Reference state, from the requirements.
    int ph = 0, u = 0;
    int lR, lM, lD, lT, lK;
    bit lden, lten, lmode;
    bit dn_flag;

    function automatic int nz(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input string req, input string name, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s (frame %s) %s got %0b expected %0b at %0t", req, frame_tag, name, got, exp, $time);
        end
    endtask

    // Driver: one cycle of stimulus, reference update and expected push.
    task automatic step(input bit s, input bit t);
        bit adv;
        bit inw;
        logic [4:0] e;
        start = s;
        line_tick = t;
        @(posedge clk);
        dn_flag = 0;
        adv = lmode ? 1'b1 : t;
        if (ph == 0) begin
            if (s) begin
                // R9: capture at accept; R6/R7: clamp and zero as one.
                lR = nz(int'(reset_len));
                lM = nz(int'(integ_main));
                lD = nz(int'(integ_ds)); if (lD > lM) lD = lM;
                lT = nz(int'(integ_ts)); if (lT > lD) lT = lD;
                lK = nz(int'(knee_len));
                lden = ds_enable; lten = ts_enable; lmode = unit_is_clk;
                ph = 1; u = 0;
            end
        end else if (adv) begin
            u++;
            if (ph == 1 && u == lR) begin ph = 2; u = 0; end
            else if (ph == 2 && u == lM) begin ph = 0; u = 0; dn_flag = 1; end
        end
        inw = (ph == 2);
        e[4] = (ph == 1);
        e[3] = inw && lden && (u >= lM - lD) && (u < lM - lD + lK);
        e[2] = inw && lten && (u >= lM - lT) && (u < lM - lT + lK);
        e[1] = inw;
        e[0] = dn_flag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare outputs with the scoreboard, away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                logic [4:0] e;
                e = sb_q.pop_front();
                chk("R1", "glob_rst", glob_rst, e[4]);
                chk("R4", "ds_rst", ds_rst, e[3]);
                chk("R5", "ts_rst", ts_rst, e[2]);
                chk("R2", "integrating", integrating, e[1]);
                chk("R2", "done", done, e[0]);
            end
        end
    end

    task automatic set_cfg(input int r, input int m, input int d, input int t, input int k,
                           input bit de, input bit te, input bit mode);
        reset_len = W'(r); integ_main = W'(m); integ_ds = W'(d); integ_ts = W'(t);
        knee_len = W'(k); ds_enable = de; ts_enable = te; unit_is_clk = mode;
    endtask

    // One frame: start, run to done, two idle cycles.
    // poke: extra starts while running (R8); change: new settings mid-frame (R9).
    task automatic frame(input string tag, input int tickp, input bit poke, input bit change);
        frame_tag = tag;
        step(1'b1, 1'b0);
        for (int n = 0; n < 4000; n++) begin
            if (change && n == 2) set_cfg(1, 1, 1, 1, 1, ~ds_enable, ~ts_enable, ~unit_is_clk);
            step(poke && (n % 4 == 1), (n % tickp) == tickp - 1);
            if (dn_flag) break;
        end
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; line_tick = 1'b0;
        set_cfg(0, 0, 0, 0, 0, 0, 0, 1);
        repeat (3) @(negedge clk);
        // R10: outputs low during reset.
        chk("R10", "reset outputs", |{glob_rst, ds_rst, ts_rst, integrating, done}, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "post-reset outputs", |{glob_rst, ds_rst, ts_rst, integrating, done}, 1'b0);

        set_cfg(3, 10, 4, 2, 2, 1, 1, 1);  frame("R1", 1, 0, 0);
        set_cfg(2, 5, 3, 1, 1, 1, 1, 0);   frame("R3", 3, 0, 0);
        set_cfg(4, 9, 6, 3, 2, 1, 1, 0);   frame("R3", 2, 0, 0);
        set_cfg(2, 8, 20, 30, 3, 1, 1, 1); frame("R6", 1, 0, 0);
        set_cfg(1, 9, 5, 7, 2, 1, 1, 1);   frame("R6", 1, 0, 0);
        set_cfg(0, 0, 0, 0, 0, 1, 1, 1);   frame("R7", 1, 0, 0);
        set_cfg(0, 3, 0, 0, 0, 1, 1, 0);   frame("R7", 2, 0, 0);
        set_cfg(2, 7, 4, 2, 2, 0, 1, 1);   frame("R4", 1, 0, 0);
        set_cfg(2, 7, 4, 2, 2, 1, 0, 1);   frame("R5", 1, 0, 0);
        set_cfg(1, 6, 3, 2, 50, 1, 1, 1);  frame("R4", 1, 0, 0);
        set_cfg(3, 12, 5, 2, 2, 1, 1, 1);  frame("R8", 1, 1, 0);
        set_cfg(2, 10, 6, 3, 2, 1, 1, 1);  frame("R9", 1, 0, 1);
        set_cfg(3, 8, 5, 2, 1, 1, 1, 0);   frame("R9", 3, 1, 1);
        set_cfg(255, 255, 200, 100, 20, 1, 1, 1); frame("R2", 1, 0, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule